// File: doc/BRIEF.md
# Clock Manager Reset Supervisor

This block drives the reset of a clock-synthesis primitive, such as a multiplier that makes a 96 MHz clock from a 32 MHz reference. It also watches the primitive's lock indication. It runs entirely on the reference clock.

An active-low pushbutton resets the block. The pushbutton input is synchronized before use. Once the reference is reported stable, the block holds the primitive in reset for a minimum number of cycles. It then waits for lock. If lock never arrives, a timeout issues a fresh reset pulse.

After lock has been gained, short dropouts of the lock signal are filtered out. A dropout that lasts for the whole filter window restarts the reset sequence. The downstream logic gets a system reset that stays asserted from any primitive reset until lock has been seen for several cycles in a row. A status flag reports that the primitive is currently locked.

Top module: `ckmgr_rst_sup`

## Requirements
- R1: While `btn_rst_n` is low, `prim_rst` and `sys_rst` are 1 and `lock_ok` is 0. After the rising edge, the release reaches the sequencer through a two-flop synchronizer, so `prim_rst` is still 1 on the first cycle after release.
- R2: Once `ref_stable` is high, `prim_rst` stays high for exactly RST_CYCLES consecutive cycles (default 3) before it is released.
- R3: While `ref_stable` is low, `prim_rst` stays high. If `ref_stable` drops during the pulse, the pulse count starts again, so `prim_rst` is released only after a cycle in which `ref_stable` was high.
- R4: After `prim_rst` is released, the first cycle sampled with `pll_locked` high makes `lock_ok` go high on the next cycle.
- R5: `sys_rst` is released only after `pll_locked` has been sampled high for LOCK_RUN consecutive cycles (default 4) outside primitive reset. Any low sample restarts that run.
- R6: Once locked, a loss of lock shorter than LOSS_CYCLES consecutive samples (default 16) is ignored. `prim_rst` and `sys_rst` stay low, and `lock_ok` is low only while the loss lasts.
- R7: A loss of lock lasting LOSS_CYCLES consecutive samples raises `prim_rst` and `sys_rst` on the next cycle and starts a new reset pulse.
- R8: Before the first lock, a low `pll_locked` never triggers loss recovery. If lock is not seen within ACQ_TIMEOUT cycles after release (default 65536), a new reset pulse is issued.
- R9: `sys_rst` is high whenever `prim_rst` is high.
- R10: A pushbutton press in any state, including the locked state, returns the block to the reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock that runs the supervisor |
| btn_rst_n | input | 1 | Board pushbutton reset, active low, asynchronous |
| ref_stable | input | 1 | High when the reference clock has settled |
| pll_locked | input | 1 | Lock indication from the clock primitive |
| prim_rst | output | 1 | Active-high reset to the clock primitive |
| sys_rst | output | 1 | Active-high reset for the downstream logic |
| lock_ok | output | 1 | High while the primitive is considered locked |

## Verification
The hardest situation to reach is the filter boundary. A loss of exactly LOSS_CYCLES-1 samples must be ignored, and a loss one sample longer must cause a reset. This is only meaningful after a full acquisition has completed.

The stimulus first completes a reset pulse and a lock acquisition. It then drops `pll_locked` for 15 and then 16 cycles, with relocks in between. It also holds the reference unstable in the middle of a pulse, and starves lock long enough for the acquisition timeout to fire.

A cycle-by-cycle model in the bench predicts all three outputs on every cycle.

// File: rtl/ckmgr_pkg.sv
package ckmgr_pkg;
    typedef enum logic [2:0] {
        ST_WAIT_STABLE,
        ST_RESET_PULSE,
        ST_WAIT_LOCK,
        ST_LOCKED,
        ST_LOSS_FILTER
    } sup_state_e;
endpackage

// File: rtl/ckmgr_btn_sync.sv
// Brings the active-low pushbutton into the reference domain.
// Assertion is asynchronous; release takes STAGES edges.
module ckmgr_btn_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic hold
);
    logic [STAGES-1:0] shift_d, shift_q;

    always_comb begin
        shift_d = {shift_q[STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) shift_q <= '0;
        else         shift_q <= shift_d;
    end

    assign hold = ~shift_q[STAGES-1];
endmodule

// File: rtl/ckmgr_seq.sv
// Sequencer: reset pulse, lock acquisition with timeout, lock-loss filter.
module ckmgr_seq
    import ckmgr_pkg::*;
#(
    parameter int RST_CYCLES  = 3,
    parameter int LOSS_CYCLES = 16,
    parameter int ACQ_TIMEOUT = 65536
) (
    input  logic       clk,
    input  logic       arst_n,
    input  logic       hold,
    input  logic       ref_stable,
    input  logic       locked,
    output logic       restart,
    output logic       prim_rst,
    output logic       lock_ok
);
    localparam int MAXC = (ACQ_TIMEOUT > LOSS_CYCLES)
                        ? ((ACQ_TIMEOUT > RST_CYCLES) ? ACQ_TIMEOUT : RST_CYCLES)
                        : ((LOSS_CYCLES > RST_CYCLES) ? LOSS_CYCLES : RST_CYCLES);
    localparam int CW = $clog2(MAXC + 1);
    localparam logic [CW-1:0] PULSE_LAST = CW'(RST_CYCLES - 1);
    localparam logic [CW-1:0] ACQ_LAST   = CW'(ACQ_TIMEOUT - 1);
    localparam logic [CW-1:0] LOSS_LAST  = CW'(LOSS_CYCLES - 1);
    localparam bit            LOSS_ONE   = (LOSS_CYCLES < 2);

    typedef struct packed {
        sup_state_e      st;
        logic [CW-1:0]   cnt;
    } seq_t;

    seq_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.st)
            ST_WAIT_STABLE: begin
                if (ref_stable) begin
                    nxt_d.st  = ST_RESET_PULSE;
                    nxt_d.cnt = '0;
                end
            end
            ST_RESET_PULSE: begin
                if (!ref_stable) begin
                    nxt_d.st  = ST_WAIT_STABLE;
                    nxt_d.cnt = '0;
                end else if (cur_q.cnt == PULSE_LAST) begin
                    nxt_d.st  = ST_WAIT_LOCK;
                    nxt_d.cnt = '0;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end
            ST_WAIT_LOCK: begin
                if (locked) begin
                    nxt_d.st  = ST_LOCKED;
                    nxt_d.cnt = '0;
                end else if (cur_q.cnt == ACQ_LAST) begin
                    nxt_d.st  = ST_RESET_PULSE;
                    nxt_d.cnt = '0;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end
            ST_LOCKED: begin
                if (!locked) begin
                    if (LOSS_ONE) begin
                        nxt_d.st  = ST_RESET_PULSE;
                        nxt_d.cnt = '0;
                    end else begin
                        nxt_d.st  = ST_LOSS_FILTER;
                        nxt_d.cnt = CW'(1);
                    end
                end
            end
            ST_LOSS_FILTER: begin
                if (locked) begin
                    nxt_d.st  = ST_LOCKED;
                    nxt_d.cnt = '0;
                end else if (cur_q.cnt == LOSS_LAST) begin
                    nxt_d.st  = ST_RESET_PULSE;
                    nxt_d.cnt = '0;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end
            default: begin
                nxt_d.st  = ST_RESET_PULSE;
                nxt_d.cnt = '0;
            end
        endcase
        if (hold) begin
            nxt_d.st  = ST_RESET_PULSE;
            nxt_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cur_q.st  <= ST_RESET_PULSE;
            cur_q.cnt <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign restart  = (nxt_d.st == ST_WAIT_STABLE) || (nxt_d.st == ST_RESET_PULSE);
    assign prim_rst = (cur_q.st == ST_WAIT_STABLE) || (cur_q.st == ST_RESET_PULSE);
    assign lock_ok  = (cur_q.st == ST_LOCKED);
endmodule

// File: rtl/ckmgr_lock_run.sv
// Holds the downstream reset until lock has been seen LOCK_RUN cycles in a row.
module ckmgr_lock_run #(
    parameter int LOCK_RUN = 4
) (
    input  logic clk,
    input  logic arst_n,
    input  logic restart,
    input  logic in_reset,
    input  logic locked,
    output logic sys_rst
);
    localparam int RW = $clog2(LOCK_RUN + 1);
    localparam logic [RW-1:0] RUN_DONE = RW'(LOCK_RUN);

    typedef struct packed {
        logic [RW-1:0] run;
        logic          srst;
    } run_t;

    run_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (restart) begin
            nxt_d.run  = '0;
            nxt_d.srst = 1'b1;
        end else begin
            if (locked && !in_reset)
                nxt_d.run = (cur_q.run == RUN_DONE) ? cur_q.run : cur_q.run + 1'b1;
            else
                nxt_d.run = '0;
            if (nxt_d.run == RUN_DONE) nxt_d.srst = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cur_q.run  <= '0;
            cur_q.srst <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign sys_rst = cur_q.srst;
endmodule

// File: rtl/ckmgr_rst_sup.sv
module ckmgr_rst_sup #(
    parameter int RST_CYCLES  = 3,
    parameter int LOSS_CYCLES = 16,
    parameter int ACQ_TIMEOUT = 65536,
    parameter int LOCK_RUN    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_ref,
    input  logic btn_rst_n,
    input  logic ref_stable,
    input  logic pll_locked,
    output logic prim_rst,
    output logic sys_rst,
    output logic lock_ok
);
    logic btn_hold;
    logic seq_restart;
    logic seq_prim;

    ckmgr_btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk_ref),
        .arst_n (btn_rst_n),
        .hold   (btn_hold)
    );

    ckmgr_seq #(
        .RST_CYCLES  (RST_CYCLES),
        .LOSS_CYCLES (LOSS_CYCLES),
        .ACQ_TIMEOUT (ACQ_TIMEOUT)
    ) u_seq (
        .clk        (clk_ref),
        .arst_n     (btn_rst_n),
        .hold       (btn_hold),
        .ref_stable (ref_stable),
        .locked     (pll_locked),
        .restart    (seq_restart),
        .prim_rst   (seq_prim),
        .lock_ok    (lock_ok)
    );

    ckmgr_lock_run #(.LOCK_RUN(LOCK_RUN)) u_run (
        .clk      (clk_ref),
        .arst_n   (btn_rst_n),
        .restart  (seq_restart),
        .in_reset (seq_prim),
        .locked   (pll_locked),
        .sys_rst  (sys_rst)
    );

    assign prim_rst = seq_prim;
endmodule

// File: rtl/ckmgr_rst_sup_chk.sv
module ckmgr_rst_sup_chk #(
    parameter int RST_CYCLES  = 3,
    parameter int LOSS_CYCLES = 16,
    parameter int LOCK_RUN    = 4
) (
    input logic clk_ref,
    input logic btn_rst_n,
    input logic ref_stable,
    input logic pll_locked,
    input logic prim_rst,
    input logic sys_rst,
    input logic lock_ok
);
    localparam int PW = $clog2(RST_CYCLES + 1);
    localparam int LW = $clog2(LOCK_RUN + 1);

    logic [PW-1:0] pulse_run_q;
    logic [LW-1:0] lock_run_q;

    always_ff @(posedge clk_ref or negedge btn_rst_n) begin
        if (!btn_rst_n) begin
            pulse_run_q <= '0;
            lock_run_q  <= '0;
        end else begin
            if (prim_rst && ref_stable)
                pulse_run_q <= (pulse_run_q == PW'(RST_CYCLES)) ? pulse_run_q : pulse_run_q + 1'b1;
            else
                pulse_run_q <= '0;
            if (pll_locked)
                lock_run_q <= (lock_run_q == LW'(LOCK_RUN)) ? lock_run_q : lock_run_q + 1'b1;
            else
                lock_run_q <= '0;
        end
    end

    AST_BTN_RELEASE_HELD: assert property (@(posedge clk_ref) disable iff (!btn_rst_n)
        $rose(btn_rst_n) |-> (prim_rst && sys_rst && !lock_ok)); // R1
    AST_PULSE_LEN: assert property (@(posedge clk_ref) disable iff (!btn_rst_n)
        $fell(prim_rst) |-> (pulse_run_q >= PW'(RST_CYCLES))); // R2
    AST_STABLE_AT_RELEASE: assert property (@(posedge clk_ref) disable iff (!btn_rst_n)
        $fell(prim_rst) |-> $past(ref_stable)); // R3
    AST_SYS_AFTER_RUN: assert property (@(posedge clk_ref) disable iff (!btn_rst_n)
        $fell(sys_rst) |-> (lock_run_q >= LW'(LOCK_RUN))); // R5
    AST_SHORT_LOSS_IGNORED: assert property (@(posedge clk_ref) disable iff (!btn_rst_n)
        (lock_ok && !pll_locked && (LOSS_CYCLES > 1)) |=> !prim_rst); // R6
    AST_SYS_COVERS_PRIM: assert property (@(posedge clk_ref) disable iff (!btn_rst_n)
        prim_rst |-> sys_rst); // R9
endmodule

bind ckmgr_rst_sup ckmgr_rst_sup_chk #(
    .RST_CYCLES  (RST_CYCLES),
    .LOSS_CYCLES (LOSS_CYCLES),
    .LOCK_RUN    (LOCK_RUN)
) u_chk (
    .clk_ref    (clk_ref),
    .btn_rst_n  (btn_rst_n),
    .ref_stable (ref_stable),
    .pll_locked (pll_locked),
    .prim_rst   (prim_rst),
    .sys_rst    (sys_rst),
    .lock_ok    (lock_ok)
);

// File: tb/ckmgr_rst_sup_test.sv
`timescale 1ns/1ps
module ckmgr_rst_sup_test;
    localparam int P_RST  = 3;
    localparam int P_LOSS = 16;
    localparam int P_ACQ  = 100;
    localparam int P_RUN  = 4;

    logic clk = 1'b0;
    logic btn_rst_n = 1'b0;
    logic ref_stable = 1'b0;
    logic pll_locked = 1'b0;
    logic prim_rst, sys_rst, lock_ok;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    always #5 clk = ~clk;

    ckmgr_rst_sup #(
        .RST_CYCLES (P_RST),
        .LOSS_CYCLES(P_LOSS),
        .ACQ_TIMEOUT(P_ACQ),
        .LOCK_RUN   (P_RUN)
    ) uut (
        .clk_ref   (clk),
        .btn_rst_n (btn_rst_n),
        .ref_stable(ref_stable),
        .pll_locked(pll_locked),
        .prim_rst  (prim_rst),
        .sys_rst   (sys_rst),
        .lock_ok   (lock_ok)
    );

    // Behavioural reference: phases 0 settle, 1 pulse, 2 acquire, 3 run, 4 filter
    int m_s1, m_s2, m_phase, m_cnt, m_run, m_sys;

    always @(posedge clk or negedge btn_rst_n) begin
        if (!btn_rst_n) begin
            m_s1 = 0; m_s2 = 0; m_phase = 1; m_cnt = 0; m_run = 0; m_sys = 1;
        end else begin
            int np, nc, nr;
            bit held, in_rst;
            held   = (m_s2 == 0);
            in_rst = (m_phase <= 1);
            m_s2 = m_s1;
            m_s1 = 1;
            np = m_phase; nc = m_cnt;
            if (m_phase == 0) begin
                if (ref_stable) begin np = 1; nc = 0; end
            end else if (m_phase == 1) begin
                if (!ref_stable) begin np = 0; nc = 0; end
                else if (m_cnt + 1 >= P_RST) begin np = 2; nc = 0; end
                else nc = m_cnt + 1;
            end else if (m_phase == 2) begin
                if (pll_locked) begin np = 3; nc = 0; end
                else if (m_cnt + 1 >= P_ACQ) begin np = 1; nc = 0; end
                else nc = m_cnt + 1;
            end else if (m_phase == 3) begin
                if (!pll_locked) begin np = 4; nc = 1; end
            end else begin
                if (pll_locked) begin np = 3; nc = 0; end
                else if (m_cnt + 1 >= P_LOSS) begin np = 1; nc = 0; end
                else nc = m_cnt + 1;
            end
            if (held) begin np = 1; nc = 0; end
            if (np <= 1) begin
                nr = 0; m_sys = 1;
            end else begin
                nr = (pll_locked && !in_rst) ? ((m_run >= P_RUN) ? P_RUN : m_run + 1) : 0;
                if (nr == P_RUN) m_sys = 0;
            end
            m_phase = np; m_cnt = nc; m_run = nr;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            bit ep, es, el;
            ep = (m_phase <= 1);
            es = (m_sys != 0);
            el = (m_phase == 3);
            checks++;
            if (prim_rst !== ep || sys_rst !== es || lock_ok !== el) begin
                failures++;
                $display("FAIL %s cycle %0d: prim/sys/lock actual %b%b%b expected %b%b%b",
                         cur_req, cycles, prim_rst, sys_rst, lock_ok, ep, es, el);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog: actual cycles %0d expected below 20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic spot(input string req, input logic a, input logic e);
        checks++;
        if (a !== e) begin
            failures++;
            $display("FAIL %s spot check: actual %b expected %b", req, a, e);
        end
    endtask

    initial begin
        step(4);
        // R1: reset state while the button is held
        spot("R1", prim_rst, 1'b1);
        spot("R1", sys_rst, 1'b1);
        spot("R1", lock_ok, 1'b0);
        btn_rst_n = 1'b1;
        step(1);
        spot("R1", prim_rst, 1'b1);
        cur_req = "R3";
        step(8);
        spot("R3", prim_rst, 1'b1);
        ref_stable = 1'b1;
        cur_req = "R2";
        step(2);
        cur_req = "R3";
        ref_stable = 1'b0;
        step(1);
        ref_stable = 1'b1;
        cur_req = "R2";
        step(5);
        spot("R2", prim_rst, 1'b0);
        cur_req = "R8";
        step(110);
        cur_req = "R4";
        pll_locked = 1'b1;
        step(2);
        spot("R4", lock_ok, 1'b1);
        cur_req = "R5";
        pll_locked = 1'b0;
        step(1);
        pll_locked = 1'b1;
        step(8);
        spot("R5", sys_rst, 1'b0);
        cur_req = "R6";
        pll_locked = 1'b0;
        step(5);
        pll_locked = 1'b1;
        step(6);
        pll_locked = 1'b0;
        step(P_LOSS - 1);
        pll_locked = 1'b1;
        step(1);
        spot("R6", prim_rst, 1'b0);
        step(6);
        cur_req = "R7";
        pll_locked = 1'b0;
        step(P_LOSS);
        step(1);
        spot("R7", prim_rst, 1'b1);
        spot("R7", sys_rst, 1'b1);
        cur_req = "R9";
        step(4);
        pll_locked = 1'b1;
        step(10);
        cur_req = "R10";
        btn_rst_n = 1'b0;
        step(3);
        btn_rst_n = 1'b1;
        step(1);
        spot("R10", prim_rst, 1'b1);
        step(15);
        spot("R10", lock_ok, 1'b1);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule